// File: doc/BRIEF.md
# Coarse Page Mapper with Private Stack Window

This block turns a 16-bit address from an 8-bit CPU into a 20-bit physical address. The CPU space is cut into sixteen pages of 4 KB. A sixteen-entry table, one entry per page, gives the physical page for each. An operating system reloads this table for each process. Threads of that process then share the whole process map, including the first 4 KB page that holds the zero page.

The 256-byte stack region at CPU addresses 0x0100 to 0x01FF does not use the table. A separate stack register supplies a 256-byte physical page for it. The scheduler reloads that register on every thread switch, so each thread gets its own full-size stack while it still shares zero page and code with its siblings.

Translation is combinational from the current register contents. The CPU address goes in and the physical address comes out in the same cycle. Both the table and the stack register load through one configuration port with a 5-bit select.

Top module: `page_mapper`

## Requirements
- R1: After reset every table entry i holds the value i, so any CPU address outside the stack window maps to the same physical address zero-extended to 20 bits.
- R2: After reset the stack register holds 0x001, so stack addresses 0x0100–0x01FF map to physical 0x00100–0x001FF.
- R3: Outside the stack window, physical bits [19:12] equal the table entry selected by CPU bits [15:12], and physical bits [11:0] equal CPU bits [11:0].
- R4: When CPU bits [15:8] equal 0x01, physical bits [19:8] equal the 12-bit stack register and physical bits [7:0] equal CPU bits [7:0]. This holds whatever table entry 0 contains.
- R5: The CPU addresses 0x0000–0x00FF and 0x0200–0x0FFF, the rest of page 0, use table entry 0. A write to entry 0 does not change the translation of the stack window.
- R6: A configuration write with select 0–15 loads table entry number select with cfg_data[7:0]. cfg_data[11:8] is ignored.
- R7: A configuration write with select 16 loads the stack register with cfg_data[11:0].
- R8: A configuration write with select 17–31 changes no table entry and no stack register value.
- R9: A write takes effect at the clock edge where cfg_we is high. During that cycle the output still shows the old mapping. With cfg_we low, no stored value changes.
- R10: The physical address follows a change of cpu_addr in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 16 | Address from the CPU |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 5 | Register select: 0–15 table entry, 16 stack register |
| cfg_data | input | 12 | Configuration write data |
| phys_addr | output | 20 | Translated physical address |

## Verification
The hardest case to reach is a split page 0, where entry 0 and the stack register point to unrelated physical pages. The bench must then probe exactly the edges 0x00FF, 0x0100, 0x01FF and 0x0200 to prove the window is neither wider nor narrower than one page. The directed phase loads distinct values into entry 0 and the stack register and walks those four addresses. The random phase biases about a third of its addresses into page 0, and within page 0 into the stack window, while writes land on entry 0, on the stack register and on the unused selects.

// File: rtl/pmap_pkg.sv
`timescale 1ns/1ps
package pmap_pkg;
    localparam int CPU_AW   = 16;
    localparam int PHYS_AW  = 20;
    localparam int COARSE_OFS = 12;
    localparam int FINE_OFS = 8;
    localparam int SEL_W    = 5;
    localparam int DATA_W   = 12;
    localparam int N_PAGES  = 2 ** (CPU_AW - COARSE_OFS);
    localparam int IDX_W    = CPU_AW - COARSE_OFS;
    localparam int COARSE_W = PHYS_AW - COARSE_OFS;
    localparam int STK_W    = PHYS_AW - FINE_OFS;
    localparam int FINE_HI_W = CPU_AW - FINE_OFS;
    localparam logic [FINE_HI_W-1:0] STACK_PAGE = 8'h01;
    localparam logic [STK_W-1:0]     STACK_RST  = 12'h001;
    localparam logic [SEL_W-1:0]     STK_SEL    = SEL_W'(N_PAGES);

    typedef logic [COARSE_W-1:0] coarse_t;
    typedef logic [STK_W-1:0]    stk_t;

    typedef struct packed {
        coarse_t [N_PAGES-1:0] tab;
        stk_t                  stk;
    } map_state_t;

    function automatic map_state_t reset_state();
        map_state_t s;
        for (int i = 0; i < N_PAGES; i++) begin
            s.tab[i] = coarse_t'(i);
        end
        s.stk = STACK_RST;
        return s;
    endfunction
endpackage

// File: rtl/pmap_cfg_decode.sv
`timescale 1ns/1ps
module pmap_cfg_decode
    import pmap_pkg::*;
(
    input  logic               cfg_we,
    input  logic [SEL_W-1:0]   cfg_sel,
    output logic [N_PAGES-1:0] tab_we,
    output logic               stk_we
);
    for (genvar g = 0; g < N_PAGES; g++) begin : g_tab_dec
        assign tab_we[g] = cfg_we && (cfg_sel == SEL_W'(g));
    end

    assign stk_we = cfg_we && (cfg_sel == STK_SEL);
endmodule

// File: rtl/pmap_regs.sv
`timescale 1ns/1ps
module pmap_regs
    import pmap_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_PAGES-1:0] tab_we,
    input  logic               stk_we,
    input  logic [DATA_W-1:0]  cfg_data,
    output map_state_t         map_q
);
    map_state_t map_d;
    map_state_t st_q;

    always_comb begin
        map_d = st_q;
        for (int i = 0; i < N_PAGES; i++) begin
            if (tab_we[i]) begin
                map_d.tab[i] = cfg_data[COARSE_W-1:0];
            end
        end
        if (stk_we) begin
            map_d.stk = cfg_data[STK_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= reset_state();
        end else begin
            st_q <= map_d;
        end
    end

    assign map_q = st_q;
endmodule

// File: rtl/pmap_xlate.sv
`timescale 1ns/1ps
module pmap_xlate
    import pmap_pkg::*;
(
    input  logic [CPU_AW-1:0]  cpu_addr,
    input  map_state_t         map_q,
    output logic [PHYS_AW-1:0] phys_addr
);
    logic             in_stack;
    logic [IDX_W-1:0] page_idx;

    assign in_stack = (cpu_addr[CPU_AW-1:FINE_OFS] == STACK_PAGE);
    assign page_idx = cpu_addr[CPU_AW-1:COARSE_OFS];

    always_comb begin
        if (in_stack) begin
            phys_addr = {map_q.stk, cpu_addr[FINE_OFS-1:0]};
        end else begin
            phys_addr = {map_q.tab[page_idx], cpu_addr[COARSE_OFS-1:0]};
        end
    end
endmodule

// File: rtl/page_mapper.sv
`timescale 1ns/1ps
module page_mapper
    import pmap_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [15:0]        cpu_addr,
    input  logic               cfg_we,
    input  logic [4:0]         cfg_sel,
    input  logic [11:0]        cfg_data,
    output logic [19:0]        phys_addr
);
    logic [N_PAGES-1:0] tab_we;
    logic               stk_we;
    map_state_t         map_q;

    pmap_cfg_decode u_dec (
        .cfg_we  (cfg_we),
        .cfg_sel (cfg_sel),
        .tab_we  (tab_we),
        .stk_we  (stk_we)
    );

    pmap_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .tab_we   (tab_we),
        .stk_we   (stk_we),
        .cfg_data (cfg_data),
        .map_q    (map_q)
    );

    pmap_xlate u_xlate (
        .cpu_addr  (cpu_addr),
        .map_q     (map_q),
        .phys_addr (phys_addr)
    );
endmodule

// File: rtl/pmap_checker.sv
`timescale 1ns/1ps
module pmap_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] cpu_addr,
    input logic        cfg_we,
    input logic [4:0]  cfg_sel,
    input logic [11:0] cfg_data,
    input logic [19:0] phys_addr
);
    assert_offset_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:8] != 8'h01) |-> (phys_addr[11:0] == cpu_addr[11:0]));

    assert_stack_low_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:8] == 8'h01) |-> (phys_addr[7:0] == cpu_addr[7:0]));

    assert_entry_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel < 5'd16) |=>
        ((cpu_addr[15:12] == $past(cfg_sel[3:0]) && cpu_addr[15:8] != 8'h01)
         -> (phys_addr[19:12] == $past(cfg_data[7:0]))));

    assert_stack_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == 5'd16) |=>
        ((cpu_addr[15:8] == 8'h01) -> (phys_addr[19:8] == $past(cfg_data))));

    assert_unused_sel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel > 5'd16) |=>
        ($stable(cpu_addr) -> $stable(phys_addr)));

    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we) |=> ($stable(cpu_addr) -> $stable(phys_addr)));
endmodule

bind page_mapper pmap_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_data  (cfg_data),
    .phys_addr (phys_addr)
);

// File: tb/page_mapper_tb.sv
`timescale 1ns/1ps
module page_mapper_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_sel = '0;
    logic [11:0] cfg_data = '0;
    logic [19:0] phys_addr;

    int n_cmp = 0;
    int n_bad = 0;
    int ref_tab [16];
    int ref_stk;

    always #2.5 clk = ~clk;

    page_mapper dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_addr  (cpu_addr),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_data  (cfg_data),
        .phys_addr (phys_addr)
    );

    function automatic int expect_phys(int a);
        if ((a >> 8) == 1) return (ref_stk << 8) | (a & 8'hFF);
        return (ref_tab[a >> 12] << 12) | (a & 12'hFFF);
    endfunction

    task automatic step(input int a, input bit we, input int sel,
                        input int data, input string tag);
        int exp_v;
        @(negedge clk);
        cpu_addr = 16'(a);
        cfg_we   = we;
        cfg_sel  = 5'(sel);
        cfg_data = 12'(data);
        #0.5;
        exp_v = expect_phys(a);
        n_cmp++;
        if (int'(phys_addr) != exp_v) begin
            n_bad++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, a[15:0],
                     phys_addr, exp_v[19:0]);
        end
        @(posedge clk);
        if (we) begin
            if (sel < 16) ref_tab[sel] = data & 8'hFF;
            else if (sel == 16) ref_stk = data & 12'hFFF;
        end
    endtask

    task automatic look(input int a, input string tag);
        step(a, 1'b0, 0, 0, tag);
    endtask

    initial begin
        #100000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) ref_tab[i] = i;
        ref_stk = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 R2 R10: identity after reset, combinational follow
        for (int i = 0; i < 16; i++) look(i * 16'h1000 + 16'h0234, "R1 identity");
        look(16'h0100, "R2 stack reset");
        look(16'h01FF, "R2 stack reset");

        // R6 R3 R9: load entry 5, upper data bits ignored, old value during write cycle
        step(16'h5ABC, 1'b1, 5, 12'hFA3, "R9 old map in write cycle");
        look(16'h5ABC, "R6 entry load");
        look(16'h5001, "R3 offset pass");
        look(16'h6ABC, "R3 neighbour entry");

        // R7 R4: stack register load, window wins over entry 0
        step(16'h0000, 1'b1, 16, 12'h7E5, "R9 old map in write cycle");
        step(16'h0000, 1'b1, 0, 12'h0C4, "R5 before entry0 write");
        look(16'h0100, "R4 stack window low edge");
        look(16'h01FF, "R4 stack window high edge");
        look(16'h0180, "R7 stack load");

        // R5: rest of page 0 uses entry 0
        look(16'h00FF, "R5 below window");
        look(16'h0200, "R5 above window");
        look(16'h0FFF, "R5 end of page 0");
        step(16'h0150, 1'b1, 0, 12'h033, "R5 entry0 write");
        look(16'h0150, "R5 window unaffected by entry0");
        look(16'h0010, "R5 new entry0");

        // R8: unused selects change nothing
        for (int s = 17; s < 32; s++) step(16'h0120, 1'b1, s, 12'hABC, "R8 unused select");
        for (int i = 0; i < 16; i++) look(i * 16'h1000 + 16'h0777, "R8 table intact");
        look(16'h01AA, "R8 stack intact");

        // R9: idle cycles keep state
        for (int i = 0; i < 8; i++) step(16'h5ABC, 1'b0, 5, 12'h111, "R9 no write when idle");

        // random phase
        for (int k = 0; k < 4000; k++) begin
            int a;
            int r;
            r = int'($urandom_range(0, 9));
            if (r < 2) a = int'($urandom_range(16'h0100, 16'h01FF));
            else if (r < 4) a = int'($urandom_range(0, 16'h0FFF));
            else a = int'($urandom_range(0, 16'hFFFF));
            step(a, $urandom_range(0, 2) == 0, int'($urandom_range(0, 31)),
                 int'($urandom_range(0, 12'hFFF)), "R3 R4 R6 R7 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule